// File: doc/BRIEF.md
# Receive Code-Group Decoder with Frame-Aware Error Flag

This block sits after symbol alignment in a 100 Mb/s twisted-pair receive path. Each time the symbol strobe is high it takes one aligned 5-bit code group and sorts it: a data group becomes a 4-bit nibble for the MAC side; idle, the end-of-stream pair (T then R) and everything else are control or fault cases. Preamble, start-of-frame, payload and CRC nibbles all pass through the same way, because the block does not know about MAC fields.

The framing logic upstream supplies a frame-active indication, which goes high after the start delimiter and low once the line is idle again. The block keeps the frame context itself. It remembers a pending T, flags the end of stream when the matching R arrives, and ignores the rest of the frame after that. A single error flag reports bad code groups, idle before the end delimiter, and loss of link during a frame. The flag stays high for as long as the cause lasts. It is not a one-cycle pulse.

Top module: `rx_symbol_decoder`

## Requirements
- R1: An in-frame data group is delivered as its nibble, using this mapping (nibble = group): 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R2: Outputs change only on the clock edge that samples the strobe high. `nib_valid` is high for exactly the one clock after that edge. With no strobe, no data, end or symbol-error output is produced.
- R3: While `frame_active` is low, no code group produces `nib_valid`, `eos_flag` or an error.
- R4: T (01101) followed at the next strobe by R (00111) raises `eos_flag` for one clock after the R edge. Neither symbol produces `nib_valid` or an error.
- R5: After the end of stream, every symbol and link state is ignored (no data, no error) until `frame_active` goes low.
- R6: In frame and before the end, any group that is neither data nor idle is an error. This includes H (00100), J (11000), K (10001), an R not preceded by T, and a T followed by anything but R. A faulty group produces no `nib_valid`.
- R7: Idle (11111) in frame before the end of stream is an error.
- R8: `link_ok` low while in frame and before the end of stream sets `rx_err` at the next clock edge.
- R9: `rx_err` persists while its cause remains. The symbol cause is re-judged at each strobe, and is cleared by a good group or by any strobe outside a live frame. The link cause clears at the edge after `link_ok` returns.
- R10: After reset, `nib_valid`, `eos_flag`, `rx_err` and `nib_out` are all zero.
- R11: `nib_out` holds the last delivered nibble until the next data group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_stb | input | 1 | One-clock strobe marking a new code group |
| code_in | input | 5 | Aligned code group |
| frame_active | input | 1 | In-frame indication from the framing logic |
| link_ok | input | 1 | Link integrity status, high when good |
| nib_out | output | 4 | Last decoded data nibble |
| nib_valid | output | 1 | One-clock pulse: a new nibble is delivered |
| eos_flag | output | 1 | One-clock pulse: end-of-stream pair seen |
| rx_err | output | 1 | Receive error, held while the cause lasts |

## Verification
The assertions check the local rules on every cycle:
- data and end-of-stream never coincide;
- data appears only after a strobe inside a frame;
- an end flag always has a pending T behind it;
- a live frame with link down always shows the error;
- the error rises only after a strobe or a link loss.

Only the bench scenarios can show the full decode table, how long the error persists across several strobes, and what clears it. They also show that symbols after the end delimiter, and symbols outside a frame, are ignored.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

   typedef enum logic [2:0] {
      CLS_DATA,
      CLS_IDLE,
      CLS_TERM,
      CLS_RSET,
      CLS_BAD
   } sym_cls_e;

   localparam logic [4:0] CG_IDLE = 5'b11111;
   localparam logic [4:0] CG_T    = 5'b01101;
   localparam logic [4:0] CG_R    = 5'b00111;

   // 5-bit group carrying a given data nibble
   function automatic logic [4:0] data_group(input logic [3:0] n);
      logic [4:0] g;
      case (n)
         4'h0: g = 5'b11110;
         4'h1: g = 5'b01001;
         4'h2: g = 5'b10100;
         4'h3: g = 5'b10101;
         4'h4: g = 5'b01010;
         4'h5: g = 5'b01011;
         4'h6: g = 5'b01110;
         4'h7: g = 5'b01111;
         4'h8: g = 5'b10010;
         4'h9: g = 5'b10011;
         4'hA: g = 5'b10110;
         4'hB: g = 5'b10111;
         4'hC: g = 5'b11010;
         4'hD: g = 5'b11011;
         4'hE: g = 5'b11100;
         default: g = 5'b11101;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/rxd_symbol_map.sv
module rxd_symbol_map
   import rxd_pkg::*;
#(
   parameter int SYM_W        = 5,
   parameter int NIB_W        = 4,
   parameter int DECODE_STYLE = 0   // 0: direct case, 1: search over data table
) (
   input  logic [SYM_W-1:0] code,
   output sym_cls_e         cls,
   output logic [NIB_W-1:0] nib
);

   localparam int NUM_DATA = 1 << NIB_W;

   if (SYM_W != 5) begin : g_bad_sym
      $error("rxd_symbol_map: SYM_W must be 5");
   end
   if (NIB_W != 4) begin : g_bad_nib
      $error("rxd_symbol_map: NIB_W must be 4");
   end
   if (DECODE_STYLE != 0 && DECODE_STYLE != 1) begin : g_bad_style
      $error("rxd_symbol_map: DECODE_STYLE must be 0 or 1");
   end

   if (DECODE_STYLE == 0) begin : g_case
      always_comb begin
         cls = CLS_DATA;
         nib = '0;
         case (code)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            CG_IDLE:  cls = CLS_IDLE;
            CG_T:     cls = CLS_TERM;
            CG_R:     cls = CLS_RSET;
            default:  cls = CLS_BAD;
         endcase
      end
   end else begin : g_search
      always_comb begin
         logic hit;
         hit = 1'b0;
         nib = '0;
         for (int i = 0; i < NUM_DATA; i++) begin
            if (code == data_group(4'(i))) begin
               hit = 1'b1;
               nib = NIB_W'(i);
            end
         end
         if (hit)                 cls = CLS_DATA;
         else if (code == CG_IDLE) cls = CLS_IDLE;
         else if (code == CG_T)    cls = CLS_TERM;
         else if (code == CG_R)    cls = CLS_RSET;
         else                      cls = CLS_BAD;
      end
   end

endmodule

// File: rtl/rxd_frame_track.sv
module rxd_frame_track
   import rxd_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_stb,
   input  logic             frame_active,
   input  sym_cls_e         cls,
   input  logic [NIB_W-1:0] nib_in,
   output logic [NIB_W-1:0] nib_q,
   output logic             valid_q,
   output logic             eos_q,
   output logic             sym_bad,
   output logic             frame_live
);

   logic pend_q;
   logic ended_q;
   logic take;
   logic end_now;
   logic arm_t;

   assign frame_live = frame_active && !ended_q;

   always_comb begin
      take    = 1'b0;
      end_now = 1'b0;
      sym_bad = 1'b0;
      arm_t   = 1'b0;
      if (frame_live) begin
         if (pend_q) begin
            if (cls == CLS_RSET) end_now = 1'b1;
            else                 sym_bad = 1'b1;
         end else begin
            case (cls)
               CLS_DATA: take    = 1'b1;
               CLS_TERM: arm_t   = 1'b1;
               default:  sym_bad = 1'b1;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         ended_q <= 1'b0;
         valid_q <= 1'b0;
         eos_q   <= 1'b0;
         nib_q   <= '0;
      end else begin
         valid_q <= 1'b0;
         eos_q   <= 1'b0;
         if (!frame_active) begin
            pend_q  <= 1'b0;
            ended_q <= 1'b0;
         end else if (sym_stb) begin
            pend_q <= arm_t;
            if (end_now) ended_q <= 1'b1;
         end
         if (sym_stb && take) begin
            valid_q <= 1'b1;
            nib_q   <= nib_in;
         end
         if (sym_stb && end_now) eos_q <= 1'b1;
      end
   end

   a_r4_eos_not_data: assert property (@(posedge clk) disable iff (!rst_n)
      eos_q |-> !valid_q);
   a_r2_data_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(sym_stb));
   a_r3_data_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(frame_active));
   a_r4_eos_after_t: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eos_q) |-> $past(pend_q));

endmodule

// File: rtl/rxd_err_track.sv
module rxd_err_track (
   input  logic clk,
   input  logic rst_n,
   input  logic sym_stb,
   input  logic sym_bad,
   input  logic frame_live,
   input  logic link_ok,
   output logic rx_err
);

   logic sym_fault_q;
   logic link_fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_fault_q  <= 1'b0;
         link_fault_q <= 1'b0;
      end else begin
         if (sym_stb) sym_fault_q <= sym_bad;
         link_fault_q <= frame_live && !link_ok;
      end
   end

   assign rx_err = sym_fault_q | link_fault_q;

   a_r8_link_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_live && !link_ok) |=> rx_err);
   a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_err) |-> ($past(sym_stb) || !$past(link_ok)));

endmodule

// File: rtl/rx_symbol_decoder.sv
module rx_symbol_decoder
   import rxd_pkg::*;
#(
   parameter int SYM_W        = 5,
   parameter int NIB_W        = 4,
   parameter int DECODE_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_stb,
   input  logic [SYM_W-1:0] code_in,
   input  logic             frame_active,
   input  logic             link_ok,
   output logic [NIB_W-1:0] nib_out,
   output logic             nib_valid,
   output logic             eos_flag,
   output logic             rx_err
);

   sym_cls_e         cls;
   logic [NIB_W-1:0] nib_dec;
   logic             sym_bad;
   logic             frame_live;

   rxd_symbol_map #(
      .SYM_W(SYM_W), .NIB_W(NIB_W), .DECODE_STYLE(DECODE_STYLE)
   ) u_map (
      .code(code_in), .cls(cls), .nib(nib_dec)
   );

   rxd_frame_track #(.NIB_W(NIB_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb),
      .frame_active(frame_active), .cls(cls), .nib_in(nib_dec),
      .nib_q(nib_out), .valid_q(nib_valid), .eos_q(eos_flag),
      .sym_bad(sym_bad), .frame_live(frame_live)
   );

   rxd_err_track u_err (
      .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sym_bad(sym_bad),
      .frame_live(frame_live), .link_ok(link_ok), .rx_err(rx_err)
   );

   a_r3_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_active && sym_stb) |=> (!nib_valid && !eos_flag));

endmodule

// File: tb/sim_rx_symbol_decoder.sv
module sim_rx_symbol_decoder;

   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sym_stb = 1'b0;
   logic [4:0] code_in = 5'b0;
   logic       frame_active = 1'b0;
   logic       link_ok = 1'b1;
   logic [3:0] nib_out;
   logic       nib_valid;
   logic       eos_flag;
   logic       rx_err;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [4:0] S_I = 5'b11111, S_T = 5'b01101, S_R = 5'b00111,
                          S_H = 5'b00100, S_J = 5'b11000, S_K = 5'b10001;

   always #(PERIOD/2) clk = ~clk;

   rx_symbol_decoder u0 (
      .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .code_in(code_in),
      .frame_active(frame_active), .link_ok(link_ok), .nib_out(nib_out),
      .nib_valid(nib_valid), .eos_flag(eos_flag), .rx_err(rx_err)
   );

   function automatic logic [4:0] enc(input int n);
      case (n)
         0: return 5'b11110;   1: return 5'b01001;
         2: return 5'b10100;   3: return 5'b10101;
         4: return 5'b01010;   5: return 5'b01011;
         6: return 5'b01110;   7: return 5'b01111;
         8: return 5'b10010;   9: return 5'b10011;
         10: return 5'b10110;  11: return 5'b10111;
         12: return 5'b11010;  13: return 5'b11011;
         14: return 5'b11100;  default: return 5'b11101;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic send(input logic [4:0] c);
      @(negedge clk);
      code_in = c;
      sym_stb = 1'b1;
      @(negedge clk);
      sym_stb = 1'b0;
      code_in = 5'b0;
   endtask

   task automatic t_reset;
      chk("R10 nib_valid", nib_valid, 0);
      chk("R10 eos_flag", eos_flag, 0);
      chk("R10 rx_err", rx_err, 0);
      chk("R10 nib_out", nib_out, 0);
   endtask

   task automatic t_table;
      frame_active = 1'b1;
      link_ok = 1'b1;
      for (int n = 0; n < 16; n++) begin
         send(enc(n));
         chk("R1 nib_out", nib_out, n);
         chk("R1 nib_valid", nib_valid, 1);
         chk("R1 rx_err", rx_err, 0);
      end
      @(negedge clk);
      chk("R2 pulse ends", nib_valid, 0);
      chk("R11 nib held", nib_out, 15);
      send(S_T);
      chk("R4 T no data", nib_valid, 0);
      chk("R4 T no err", rx_err, 0);
      chk("R4 T no eos", eos_flag, 0);
      send(S_R);
      chk("R4 eos", eos_flag, 1);
      chk("R4 R no data", nib_valid, 0);
      chk("R4 R no err", rx_err, 0);
      @(negedge clk);
      chk("R4 eos pulse", eos_flag, 0);
      send(enc(3));
      chk("R5 data ignored", nib_valid, 0);
      chk("R11 nib kept", nib_out, 15);
      send(S_I);
      chk("R5 idle ignored", rx_err, 0);
      send(S_H);
      chk("R5 bad ignored", rx_err, 0);
      frame_active = 1'b0;
   endtask

   task automatic t_outside;
      frame_active = 1'b0;
      send(enc(7));
      chk("R3 no data", nib_valid, 0);
      send(5'b00000);
      chk("R3 no err", rx_err, 0);
      send(S_T);
      send(S_R);
      chk("R3 no eos", eos_flag, 0);
   endtask

   task automatic t_invalid;
      @(negedge clk);
      frame_active = 1'b1;
      send(enc(2));
      chk("R6 clean", rx_err, 0);
      send(S_H);
      chk("R6 H err", rx_err, 1);
      chk("R6 H no data", nib_valid, 0);
      @(negedge clk);
      chk("R9 held no stb", rx_err, 1);
      send(5'b00000);
      chk("R9 persists", rx_err, 1);
      send(enc(5));
      chk("R9 cleared", rx_err, 0);
      chk("R1 after err", nib_out, 5);
      send(S_J);
      chk("R6 J err", rx_err, 1);
      send(enc(1));
      send(S_K);
      chk("R6 K err", rx_err, 1);
      send(enc(1));
      send(S_R);
      chk("R6 lone R", rx_err, 1);
      chk("R6 lone R no eos", eos_flag, 0);
      send(enc(1));
      send(S_T);
      chk("R6 T pending ok", rx_err, 0);
      send(enc(9));
      chk("R6 T then data err", rx_err, 1);
      chk("R6 T then data no nib", nib_valid, 0);
      send(S_T);
      send(S_R);
      chk("R4 eos after fault", eos_flag, 1);
      chk("R4 err cleared", rx_err, 0);
      frame_active = 1'b0;
   endtask

   task automatic t_idle;
      @(negedge clk);
      frame_active = 1'b1;
      send(enc(4));
      send(S_I);
      chk("R7 idle err", rx_err, 1);
      chk("R7 idle no data", nib_valid, 0);
      send(S_I);
      chk("R9 idle persists", rx_err, 1);
      frame_active = 1'b0;
      send(S_I);
      chk("R9 clear after frame", rx_err, 0);
   endtask

   task automatic t_link;
      @(negedge clk);
      frame_active = 1'b1;
      send(enc(6));
      link_ok = 1'b0;
      @(negedge clk);
      chk("R8 link err", rx_err, 1);
      @(negedge clk);
      chk("R9 link held", rx_err, 1);
      send(enc(8));
      chk("R9 link held over data", rx_err, 1);
      chk("R1 data during link loss", nib_out, 8);
      link_ok = 1'b1;
      @(negedge clk);
      chk("R9 link clear", rx_err, 0);
      send(S_T);
      send(S_R);
      link_ok = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R5 link after end", rx_err, 0);
      frame_active = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R3 link outside frame", rx_err, 0);
      link_ok = 1'b1;
   endtask

   initial begin
      #(PERIOD * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_table;
      t_outside;
      t_invalid;
      t_idle;
      t_link;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule